// File: doc/BRIEF.md
# Write-Once Page Staging Buffer

This block holds one page of instruction words while software assembles it, ahead of a flash page commit. A load strobe delivers a word index and a 16-bit value. Each index may be filled only once between clears. A second load to a filled index is rejected and raises a sticky error flag. A per-word valid bitmap records which entries hold data. Entries that have not been loaded read as all ones, the erased-flash value.

Four events wipe the whole page at once: completion of a page write, the software re-enable strobe, an EEPROM write that arrives part-way through loading, and reset. When the write engine issues a start pulse, the block streams the page out in ascending index order, one word per cycle.

A control state machine has three states.
- `ST_EMPTY`: no word has been loaded.
- `ST_FILLING`: at least one word has been loaded.
- `ST_READOUT`: the page is being streamed out.

Its transitions are:
- **accept**: `ST_EMPTY` to `ST_FILLING`, taken on the first accepted load.
- **start**: `ST_EMPTY` or `ST_FILLING` to `ST_READOUT`, taken on `rd_start`.
- **finish**: `ST_READOUT` to `ST_FILLING`, or to `ST_EMPTY` if no entry is valid, taken after the final word.
- **wipe**: any state to `ST_EMPTY`, taken on any clear event.

A clear takes priority over every other input in the same cycle.

Top module: `page_stage_buf`

## Requirements
- R1: After reset, `valid_map` is 0, `dup_err` is 0 and `rd_valid` is 0. A readout then returns 16'hFFFF for every word.
- R2: When `ld_en` is sampled high with `ld_idx`=i on an empty entry, and no clear is present, word i takes `ld_data`. A later readout shows that value at index i.
- R3: A load to an index whose valid bit is already set has no effect on the stored data or on `valid_map`. It sets `dup_err` from the next cycle, and `dup_err` stays high until the next clear.
- R4: A high `wr_done` empties the page on the next cycle: `valid_map` goes to 0, `dup_err` goes to 0, and every word reads 16'hFFFF.
- R5: A high `reenable` empties the page in the same way as R4.
- R6: A high `ee_wr` empties the page in the same way as R4, discarding every word loaded so far.
- R7: A `rd_start` accepted at a clock edge makes `rd_valid` high for the following PAGE_WORDS cycles. During those cycles `rd_idx` counts 0, 1, … PAGE_WORDS-1, and `rd_last` is high only on the final word. `rd_valid` then falls, and the stored contents are unchanged.
- R8: A word whose valid bit is clear reads as 16'hFFFF on `rd_data`.
- R9: A load presented while `rd_valid` is high is ignored: it changes neither the data nor `valid_map`.
- R10: A clear takes priority. A load in the same cycle as a clear is dropped. A clear during readout stops the stream, so `rd_valid` is 0 from the next cycle.
- R11: Bit i of `valid_map` is 1 exactly when word i has been accepted since the last clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_idx | input | IDX_W | Word index within the page |
| ld_data | input | DATA_W | Word value to load |
| wr_done | input | 1 | Page write completed (clear) |
| reenable | input | 1 | Software re-enable strobe (clear) |
| ee_wr | input | 1 | EEPROM write event (clear) |
| rd_start | input | 1 | Start the commit readout |
| rd_valid | output | 1 | Readout word present |
| rd_idx | output | IDX_W | Index of the word presented |
| rd_data | output | DATA_W | Word value, or all ones if the word was never loaded |
| rd_last | output | 1 | Final word of the readout |
| valid_map | output | PAGE_WORDS | Per-word loaded flags |
| dup_err | output | 1 | Sticky flag for a rejected duplicate load |

## Verification
The bench builds the block with PAGE_WORDS=8 and DATA_W=16. With these values a full page fill and a complete readout each take only a few cycles. This puts within reach the boundary at the last index, the `rd_last` timing and the full 8-bit valid bitmap. It also allows many clear, duplicate and mid-readout sequences to be replayed one after another without a long run.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_FILLING = 2'd1,
        ST_READOUT = 2'd2
    } pgbuf_state_e;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int PAGE_WORDS = 128,
    parameter int DATA_W     = 16,
    parameter int IDX_W      = $clog2(PAGE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [IDX_W-1:0]      sel_idx,
    output logic [DATA_W-1:0]     sel_word,
    output logic [PAGE_WORDS-1:0] valid_q,
    output logic                  accept,
    output logic                  dup_hit
);
    logic [DATA_W-1:0] mem_q  [PAGE_WORDS];
    logic [DATA_W-1:0] word_v [PAGE_WORDS];

    always_comb begin
        accept  = wr_en && !clear && !valid_q[wr_idx];
        dup_hit = wr_en && !clear &&  valid_q[wr_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clear) begin
            valid_q <= '0;
        end else if (accept) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Data storage carries no reset; the valid mask supplies the erased value.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_word
        assign word_v[i] = valid_q[i] ? mem_q[i] : {DATA_W{1'b1}};
    end

    assign sel_word = word_v[sel_idx];
endmodule

// File: rtl/pgbuf_reader.sv
module pgbuf_reader #(
    parameter int PAGE_WORDS = 128,
    parameter int IDX_W      = $clog2(PAGE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             running,
    output logic [IDX_W-1:0] cnt_q,
    output logic             at_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_WORDS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (running) begin
            cnt_q <= IDX_W'(cnt_q + 1'b1);
        end
    end

    assign at_last = running && (cnt_q == LAST_IDX);
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic rd_start,
    input  logic accept,
    input  logic dup_hit,
    input  logic at_last,
    input  logic any_valid,
    output logic load_open,
    output logic start_ok,
    output logic running,
    output logic dup_err
);
    pgbuf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (clear)         state_d = ST_EMPTY;
                else if (rd_start) state_d = ST_READOUT;
                else if (accept)   state_d = ST_FILLING;
            end
            ST_FILLING: begin
                if (clear)         state_d = ST_EMPTY;
                else if (rd_start) state_d = ST_READOUT;
            end
            ST_READOUT: begin
                if (clear)         state_d = ST_EMPTY;
                else if (at_last)  state_d = (any_valid || accept) ? ST_FILLING : ST_EMPTY;
            end
            default:               state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        load_open = (state_q != ST_READOUT);
        running   = (state_q == ST_READOUT);
        start_ok  = (state_q != ST_READOUT) && rd_start && !clear;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dup_err <= 1'b0;
        end else if (clear) begin
            dup_err <= 1'b0;
        end else if (dup_hit) begin
            dup_err <= 1'b1;
        end
    end
endmodule

// File: rtl/page_stage_buf.sv
module page_stage_buf #(
    parameter int PAGE_WORDS = 128,
    parameter int DATA_W     = 16,
    localparam int IDX_W     = $clog2(PAGE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_en,
    input  logic [IDX_W-1:0]      ld_idx,
    input  logic [DATA_W-1:0]     ld_data,
    input  logic                  wr_done,
    input  logic                  reenable,
    input  logic                  ee_wr,
    input  logic                  rd_start,
    output logic                  rd_valid,
    output logic [IDX_W-1:0]      rd_idx,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_last,
    output logic [PAGE_WORDS-1:0] valid_map,
    output logic                  dup_err
);
    logic clear_any;
    logic load_open, start_ok, running;
    logic accept, dup_hit, at_last;
    logic [IDX_W-1:0] cnt;

    assign clear_any = wr_done || reenable || ee_wr;

    pgbuf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_any),
        .rd_start  (rd_start),
        .accept    (accept),
        .dup_hit   (dup_hit),
        .at_last   (at_last),
        .any_valid (|valid_map),
        .load_open (load_open),
        .start_ok  (start_ok),
        .running   (running),
        .dup_err   (dup_err)
    );

    pgbuf_store #(
        .PAGE_WORDS (PAGE_WORDS),
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_any),
        .wr_en    (ld_en && load_open),
        .wr_idx   (ld_idx),
        .wr_data  (ld_data),
        .sel_idx  (cnt),
        .sel_word (rd_data),
        .valid_q  (valid_map),
        .accept   (accept),
        .dup_hit  (dup_hit)
    );

    pgbuf_reader #(
        .PAGE_WORDS (PAGE_WORDS),
        .IDX_W      (IDX_W)
    ) u_reader (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_ok),
        .running (running),
        .cnt_q   (cnt),
        .at_last (at_last)
    );

    assign rd_valid = running;
    assign rd_idx   = cnt;
    assign rd_last  = at_last;
endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk #(
    parameter int PAGE_WORDS = 128,
    parameter int DATA_W     = 16,
    parameter int IDX_W      = $clog2(PAGE_WORDS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ld_en,
    input logic [IDX_W-1:0]      ld_idx,
    input logic                  wr_done,
    input logic                  reenable,
    input logic                  ee_wr,
    input logic                  rd_valid,
    input logic [IDX_W-1:0]      rd_idx,
    input logic [DATA_W-1:0]     rd_data,
    input logic                  rd_last,
    input logic [PAGE_WORDS-1:0] valid_map,
    input logic                  dup_err
);
    logic clr;
    assign clr = wr_done || reenable || ee_wr;

    // R3
    dup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err && !clr |=> dup_err);

    // R3
    dup_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en && valid_map[ld_idx] && !clr |=> $stable(valid_map));

    // R4
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (valid_map == '0) && !dup_err);

    // R7
    readout_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_last && !clr |=> rd_valid && (rd_idx == IDX_W'($past(rd_idx) + 1'b1)));

    // R7
    readout_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_last |=> !rd_valid);

    // R8
    erased_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !valid_map[rd_idx] |-> rd_data == {DATA_W{1'b1}});

    // R9
    readout_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !clr |=> $stable(valid_map));

    // R10
    clear_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !rd_valid);
endmodule

bind page_stage_buf pgbuf_chk #(
    .PAGE_WORDS (PAGE_WORDS),
    .DATA_W     (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .ld_idx    (ld_idx),
    .wr_done   (wr_done),
    .reenable  (reenable),
    .ee_wr     (ee_wr),
    .rd_valid  (rd_valid),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .rd_last   (rd_last),
    .valid_map (valid_map),
    .dup_err   (dup_err)
);

// File: tb/page_stage_buf_test.sv
module page_stage_buf_test;
    localparam int PW = 8;
    localparam int DW = 16;
    localparam int IW = $clog2(PW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [DW-1:0] ld_data = '0;
    logic          wr_done = 1'b0, reenable = 1'b0, ee_wr = 1'b0, rd_start = 1'b0;
    logic          rd_valid, rd_last, dup_err;
    logic [IW-1:0] rd_idx;
    logic [DW-1:0] rd_data;
    logic [PW-1:0] valid_map;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] m_mem [PW];
    logic [PW-1:0] m_valid = '0;
    logic          m_dup = 1'b0;

    logic [IW+DW:0] exp_q [$];
    string          tag_q [$];

    always #4 clk = ~clk;

    page_stage_buf #(.PAGE_WORDS(PW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .wr_done(wr_done), .reenable(reenable), .ee_wr(ee_wr), .rd_start(rd_start),
        .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data), .rd_last(rd_last),
        .valid_map(valid_map), .dup_err(dup_err)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: compares every streamed word with the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected word", {rd_last, rd_idx, rd_data}, 0);
            end else begin
                logic [IW+DW:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({rd_last, rd_idx, rd_data} == e, t, {rd_last, rd_idx, rd_data}, e);
            end
        end
    end

    task automatic model_clear();
        m_valid = '0;
        m_dup   = 1'b0;
    endtask

    task automatic check_state(input string tag);
        @(negedge clk);
        check(valid_map == m_valid, {tag, " valid_map"}, valid_map, m_valid);
        check(dup_err == m_dup, {tag, " dup_err"}, dup_err, m_dup);
    endtask

    task automatic load(input int idx, input logic [DW-1:0] d);
        @(posedge clk); #1;
        ld_en = 1'b1; ld_idx = IW'(idx); ld_data = d;
        @(posedge clk); #1;
        ld_en = 1'b0;
        if (m_valid[idx]) m_dup = 1'b1;
        else begin m_valid[idx] = 1'b1; m_mem[idx] = d; end
    endtask

    task automatic clear_ev(input int kind);
        @(posedge clk); #1;
        if (kind == 0) wr_done = 1'b1;
        else if (kind == 1) reenable = 1'b1;
        else ee_wr = 1'b1;
        @(posedge clk); #1;
        wr_done = 1'b0; reenable = 1'b0; ee_wr = 1'b0;
        model_clear();
    endtask

    task automatic push_word(input int i, input string tag);
        logic [DW-1:0] w;
        w = m_valid[i] ? m_mem[i] : {DW{1'b1}};
        exp_q.push_back({(i == PW - 1), IW'(i), w});
        tag_q.push_back(tag);
    endtask

    // Driver: queues the expected page and requests it; optionally loads mid-stream.
    task automatic readout(input string tag, input bit inject);
        for (int i = 0; i < PW; i++) push_word(i, tag);
        @(posedge clk); #1;
        rd_start = 1'b1;
        @(posedge clk); #1;
        rd_start = 1'b0;
        if (inject) begin
            ld_en = 1'b1; ld_idx = IW'(3); ld_data = 16'hBEEF;
            @(posedge clk); #1;
            ld_en = 1'b0;
            repeat (PW - 1) @(posedge clk);
        end else begin
            repeat (PW) @(posedge clk);
        end
        @(negedge clk);
        check(!rd_valid, {tag, " stream ended"}, rd_valid, 0);
        check(exp_q.size() == 0, {tag, " all words seen"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(valid_map == '0, "R1 valid_map", valid_map, 0);
        check(!dup_err, "R1 dup_err", dup_err, 0);
        check(!rd_valid, "R1 rd_valid", rd_valid, 0);
        readout("R1 R8 reset page", 1'b0);

        load(0, 16'h1234); load(1, 16'h0000); load(2, 16'hA5A5); load(6, 16'h7F01);
        check_state("R2 R11 partial fill");
        readout("R2 R8 partial page", 1'b0);

        load(2, 16'h5555);
        check_state("R3 duplicate");
        load(5, 16'h0C0C);
        check_state("R3 sticky");
        readout("R3 data unchanged", 1'b0);

        clear_ev(0);
        check_state("R4 write done clear");
        readout("R4 page erased", 1'b0);

        for (int i = 0; i < PW; i++) load(i, DW'(16'h1000 + i * 16'h0111));
        check_state("R11 full fill");
        readout("R7 full page", 1'b0);
        load(PW - 1, 16'hFFFE);
        check_state("R3 last index dup");
        clear_ev(1);
        check_state("R5 reenable clear");

        load(4, 16'h4444); load(7, 16'h7777);
        clear_ev(2);
        check_state("R6 eeprom clear");
        readout("R6 page erased", 1'b0);

        @(posedge clk); #1;
        ld_en = 1'b1; ld_idx = IW'(2); ld_data = 16'h2222; ee_wr = 1'b1;
        @(posedge clk); #1;
        ld_en = 1'b0; ee_wr = 1'b0;
        model_clear();
        check_state("R10 load vs clear");

        load(1, 16'h0101);
        readout("R9 load during readout", 1'b1);
        check_state("R9 bitmap unchanged");
        readout("R9 data unchanged", 1'b0);

        push_word(0, "R10 abort word0");
        push_word(1, "R10 abort word1");
        @(posedge clk); #1;
        rd_start = 1'b1;
        @(posedge clk); #1;
        rd_start = 1'b0;
        @(posedge clk); #1;
        wr_done = 1'b1;
        @(posedge clk); #1;
        wr_done = 1'b0;
        model_clear();
        @(negedge clk);
        check(!rd_valid, "R10 abort stream", rd_valid, 0);
        check(exp_q.size() == 0, "R10 abort words", exp_q.size(), 0);
        check_state("R10 abort cleared");

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule